// File: doc/BRIEF.md
# One-Time-Programmable Page Controller

This block looks after a small side page of storage, 32 bytes by default, that sits outside the main memory array and may be programmed exactly once. It takes a decoded byte stream from a serial bus engine: a pulse when a device selection has been recognised (the page or the main array, read or write), a pulse per received byte, a pulse per byte handed to the master on a read, and a pulse on a bus STOP. For every page selection and every received byte it returns an acknowledge decision one clock later.

Writes must begin at page offset zero. The first accepted data byte sets a sticky lock, so one write transaction of any length is the only one the page ever takes. Reads may load an offset with a dummy write and then stream out bytes, wrapping inside the page. When a later current-address read targets the main array, the block hands the shared address counter the offset that follows the last page byte that was touched.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset every page byte reads 0xFF, and it stays 0xFF until the page is first written.
- R2: A page selection (read or write) is acknowledged, and both address bytes of a page write are acknowledged whatever their value.
- R3: A write opens only when bits [4:0] of the upper address byte and all of the lower address byte are zero; bits [7:5] of the upper byte are ignored. Otherwise its data bytes are not acknowledged and the page is unchanged.
- R4: The first accepted data byte locks the page; the rest of that transaction still writes successive offsets, and every later write has its data refused with the page unchanged.
- R5: A data byte that arrives while `wc_block` is high is refused and not stored; a write refused this way does not lock the page.
- R6: In one write, data bytes beyond the page size are refused and do not overwrite earlier offsets.
- R7: A dummy write whose address passes the check of R3 with lower byte bits [7:5] zero sets the read offset to lower byte bits [4:0]; a failing address leaves the read offset where it was.
- R8: Each byte read advances the offset; after offset 31 the next read returns offset 0.
- R9: One cycle after a main-array read selection that follows page activity, `arr_set` pulses with `arr_val` equal to the last page offset read or written plus one (32 after offset 31), or to the loaded offset if none was accessed since; a second main-array selection gives no pulse.
- R10: `ack_valid` pulses exactly one cycle after each page selection or page byte; main-array selections and bytes outside a page transaction get none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lock and erases the page |
| tgt_valid | input | 1 | Pulse: device selection decoded |
| tgt_page | input | 1 | Selection targets the page (1) or the main array (0) |
| tgt_rd | input | 1 | Selection direction, 1 = read |
| byte_valid | input | 1 | Pulse: a byte was received from the master |
| byte_data | input | 8 | Received byte |
| rd_next | input | 1 | Pulse: the byte on `rd_data` was sent to the master |
| stop | input | 1 | Pulse: bus STOP seen |
| wc_block | input | 1 | Write protection, polarity already resolved |
| ack_valid | output | 1 | An acknowledge decision is present |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_data | output | 8 | Page byte at the current read offset |
| arr_set | output | 1 | Pulse: load the main-array address counter |
| arr_val | output | 12 | Value for the main-array address counter |

## Verification
Write address checks are exercised with a nonzero bit in the checked upper field, a nonzero low offset, a nonzero bit above the offset field and a set ignored top bit. These separate the masked bits from the checked ones. Random reads walk a vector table of valid and invalid addresses, and that tells a load of the offset apart from a retained one. A 33-byte write, a write under protection and a second write attempt separate the page-size limit, protection without lock and the sticky lock. Reads across offset 31, followed by main-array selections, separate wrap-around from the handoff value of 32.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_RD
  } phase_t;

  // Upper address byte: the low nchk bits must be zero, the rest are ignored.
  function automatic logic hi_ok(input logic [7:0] b, input int unsigned nchk);
    logic [7:0] m;
    m = 8'((16'd1 << nchk) - 16'd1);
    return (b & m) == 8'd0;
  endfunction

  // Lower address byte: every bit above the page offset field must be zero.
  function automatic logic lo_ok(input logic [7:0] b, input int unsigned offw);
    return (b >> offw) == 8'd0;
  endfunction

endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = 5,
  parameter int HI_CHK     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_valid,
  input  logic             tgt_page,
  input  logic             tgt_rd,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             rd_next,
  input  logic             stop,
  input  logic             wc_block,
  input  logic             locked,
  output logic             ack_valid,
  output logic             ack_ok,
  output logic             addr_load,
  output logic [OFF_W-1:0] addr_off,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_off,
  output logic             rd_acc
);
  localparam int CNT_W = OFF_W + 1;

  phase_t           ph;
  logic             hi_good;
  logic             wr_open;
  logic [CNT_W-1:0] cnt;

  // Named events for the assertions.
  logic byte_live, in_hi, in_lo, in_dat, lo_good, room;

  always_comb begin
    byte_live = byte_valid && !tgt_valid && !stop;
    in_hi     = byte_live && (ph == PH_AHI);
    in_lo     = byte_live && (ph == PH_ALO);
    in_dat    = byte_live && (ph == PH_DATA);
    lo_good   = hi_good && lo_ok(byte_data, OFF_W);
    room      = cnt < CNT_W'(PAGE_BYTES);
    addr_load = in_lo && lo_good;
    addr_off  = byte_data[OFF_W-1:0];
    wr_en     = in_dat && wr_open && !wc_block && room;
    wr_off    = cnt[OFF_W-1:0];
    rd_acc    = rd_next && !tgt_valid && (ph == PH_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      hi_good   <= 1'b0;
      wr_open   <= 1'b0;
      cnt       <= '0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      if (tgt_valid) begin
        wr_open <= 1'b0;
        cnt     <= '0;
        if (tgt_page) begin
          ph        <= tgt_rd ? PH_RD : PH_AHI;
          ack_valid <= 1'b1;
          ack_ok    <= 1'b1;
        end else begin
          ph <= PH_IDLE;
        end
      end else if (stop) begin
        ph      <= PH_IDLE;
        wr_open <= 1'b0;
      end else if (in_hi) begin
        hi_good   <= hi_ok(byte_data, HI_CHK);
        ph        <= PH_ALO;
        ack_valid <= 1'b1;
        ack_ok    <= 1'b1;
      end else if (in_lo) begin
        wr_open   <= lo_good && (addr_off == '0) && !locked;
        ph        <= PH_DATA;
        ack_valid <= 1'b1;
        ack_ok    <= 1'b1;
      end else if (in_dat) begin
        ack_valid <= 1'b1;
        ack_ok    <= wr_en;
        if (wr_en) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_DATA_NACK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && !wr_open) |=> (ack_valid && !ack_ok)); // R3
  AST_OPEN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_open) |-> !$past(locked)); // R4
  AST_WC_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && wc_block) |=> !ack_ok); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && !room) |=> (ack_valid && !ack_ok)); // R6
  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_valid && tgt_page) || in_hi || in_lo || in_dat) |=> ack_valid); // R10
  AST_NO_ACK_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_page) |=> !ack_valid); // R10

endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             locked
);
  logic [7:0] cells [PAGE_BYTES];

  // Reset stands in for the erased state; the lock is sticky until reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= 8'hFF;
      locked <= 1'b0;
    end else if (wr_en) begin
      cells[wr_off] <= wr_data;
      locked        <= 1'b1;
    end
  end

  assign rd_data = cells[rd_off];

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr_en)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R4
  AST_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (rd_data == 8'hFF)); // R1

endmodule

// File: rtl/otp_ptr.sv
module otp_ptr #(
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = 5,
  parameter int ARR_AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [OFF_W-1:0]  addr_off,
  input  logic              acc,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              page_evt,
  input  logic              main_evt,
  input  logic              main_rd,
  output logic [OFF_W-1:0]  cur_off,
  output logic              arr_set,
  output logic [ARR_AW-1:0] arr_val
);
  localparam int NX_W = OFF_W + 1;

  // Offset that follows the last page byte touched; its low bits wrap in the page.
  logic [NX_W-1:0] nxt;
  logic            otp_last;

  function automatic logic [NX_W-1:0] follow(input logic [OFF_W-1:0] off);
    return NX_W'(off) + NX_W'(1);
  endfunction

  assign cur_off = nxt[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt      <= '0;
      otp_last <= 1'b0;
      arr_set  <= 1'b0;
      arr_val  <= '0;
    end else begin
      arr_set <= 1'b0;
      if (addr_load)     nxt <= NX_W'(addr_off);
      else if (acc)      nxt <= follow(acc_off);
      if (page_evt)      otp_last <= 1'b1;
      else if (main_evt) begin
        otp_last <= 1'b0;
        if (main_rd && otp_last) begin
          arr_set <= 1'b1;
          arr_val <= ARR_AW'(nxt);
        end
      end
    end
  end

  AST_ARR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_set |-> (arr_val <= ARR_AW'(PAGE_BYTES))); // R9
  AST_ARR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_set |=> !arr_set); // R9
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !addr_load && acc_off == OFF_W'(PAGE_BYTES - 1)) |=> (cur_off == '0)); // R8

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl #(
  parameter int PAGE_BYTES = 32,
  parameter int ARR_AW     = 12,
  parameter int HI_CHK     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_valid,
  input  logic              tgt_page,
  input  logic              tgt_rd,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              rd_next,
  input  logic              stop,
  input  logic              wc_block,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic [7:0]        rd_data,
  output logic              arr_set,
  output logic [ARR_AW-1:0] arr_val
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic             locked, addr_load, wr_en, rd_acc, acc;
  logic [OFF_W-1:0] addr_off, wr_off, cur_off, acc_off;

  otp_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .HI_CHK(HI_CHK)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_page(tgt_page),
    .tgt_rd(tgt_rd), .byte_valid(byte_valid), .byte_data(byte_data),
    .rd_next(rd_next), .stop(stop), .wc_block(wc_block), .locked(locked),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .addr_load(addr_load),
    .addr_off(addr_off), .wr_en(wr_en), .wr_off(wr_off), .rd_acc(rd_acc)
  );

  otp_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(byte_data), .rd_off(cur_off), .rd_data(rd_data), .locked(locked)
  );

  assign acc     = wr_en || rd_acc;
  assign acc_off = wr_en ? wr_off : cur_off;

  otp_ptr #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .ARR_AW(ARR_AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_off(addr_off),
    .acc(acc), .acc_off(acc_off),
    .page_evt(tgt_valid && tgt_page),
    .main_evt(tgt_valid && !tgt_page),
    .main_rd(tgt_rd),
    .cur_off(cur_off), .arr_set(arr_set), .arr_val(arr_val)
  );

endmodule

// File: tb/otp_page_ctrl_bench.sv
module otp_page_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tgt_valid = 0, tgt_page = 0, tgt_rd = 0;
  logic        byte_valid = 0, rd_next = 0, stop = 0, wc_block = 0;
  logic [7:0]  byte_data = 8'h00;
  logic        ack_valid, ack_ok, arr_set;
  logic [7:0]  rd_data;
  logic [11:0] arr_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  otp_page_ctrl u_otp_page_ctrl (
    .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_page(tgt_page),
    .tgt_rd(tgt_rd), .byte_valid(byte_valid), .byte_data(byte_data),
    .rd_next(rd_next), .stop(stop), .wc_block(wc_block),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .rd_data(rd_data),
    .arr_set(arr_set), .arr_val(arr_val)
  );

  // Random-read vectors {upper address byte, lower address byte}.
  localparam logic [15:0] RR_VEC [8] = '{
    16'h0005, 16'hE00C, 16'h0020, 16'h001F,
    16'h0800, 16'h2011, 16'h0100, 16'h4003
  };

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel(input bit pg, input bit rd, output bit av, output bit aok,
                     output bit sset, output logic [11:0] sval);
    @(negedge clk);
    tgt_valid = 1; tgt_page = pg; tgt_rd = rd;
    @(negedge clk);
    tgt_valid = 0;
    av = ack_valid; aok = ack_ok; sset = arr_set; sval = arr_val;
  endtask

  task automatic send(input logic [7:0] b, output bit av, output bit aok);
    @(negedge clk);
    byte_valid = 1; byte_data = b;
    @(negedge clk);
    byte_valid = 0;
    av = ack_valid; aok = ack_ok;
  endtask

  task automatic end_xfer();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic read_one(output logic [7:0] d);
    @(negedge clk);
    d = rd_data; rd_next = 1;
    @(negedge clk);
    rd_next = 0;
  endtask

  // Dummy write with the two address bytes, then reselect the page for reading.
  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    bit av, aok, ss; logic [11:0] sv;
    sel(1, 0, av, aok, ss, sv);
    chk(av && aok, "R2 page write select ack", {av, aok}, 3);
    send(hi, av, aok);
    chk(av && aok, "R2 upper address ack", {av, aok}, 3);
    send(lo, av, aok);
    chk(av && aok, "R2 lower address ack", {av, aok}, 3);
    sel(1, 1, av, aok, ss, sv);
    chk(av && aok, "R2 page read select ack", {av, aok}, 3);
  endtask

  task automatic read_at(input logic [7:0] lo, output logic [7:0] d);
    set_addr(8'h00, lo);
    read_one(d);
    end_xfer();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit av, aok, ss;
    logic [11:0] sv;
    logic [7:0] d;
    int model_ptr;

    repeat (3) @(negedge clk);
    chk(ack_valid == 0 && arr_set == 0, "R10 reset outputs idle", {ack_valid, arr_set}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: erased page, read 33 bytes (also wraps once)
    sel(1, 1, av, aok, ss, sv);
    chk(av && aok, "R2 read select ack", {av, aok}, 3);
    for (int i = 0; i < 33; i++) begin
      read_one(d);
      chk(d == 8'hFF, "R1 erased byte", d, 8'hFF);
    end
    end_xfer();

    // R10: byte outside a page transaction
    send(8'h12, av, aok);
    chk(av == 0, "R10 no ack outside transaction", av, 0);

    // R3: bad write addresses
    for (int k = 0; k < 3; k++) begin
      logic [7:0] hi, lo;
      hi = (k == 0) ? 8'h01 : 8'h00;
      lo = (k == 1) ? 8'h04 : ((k == 2) ? 8'h20 : 8'h00);
      sel(1, 0, av, aok, ss, sv);
      send(hi, av, aok);
      chk(av && aok, "R2 upper address ack on bad address", {av, aok}, 3);
      send(lo, av, aok);
      chk(av && aok, "R2 lower address ack on bad address", {av, aok}, 3);
      send(8'h3C, av, aok);
      chk(av && !aok, "R3 data refused on bad address", {av, aok}, 2);
      end_xfer();
    end
    read_at(8'h00, d);
    chk(d == 8'hFF, "R3 page unchanged after bad address", d, 8'hFF);

    // R5: protected write
    wc_block = 1;
    sel(1, 0, av, aok, ss, sv);
    send(8'h00, av, aok);
    send(8'h00, av, aok);
    send(8'h55, av, aok);
    chk(av && !aok, "R5 data refused under protection", {av, aok}, 2);
    end_xfer();
    wc_block = 0;
    read_at(8'h00, d);
    chk(d == 8'hFF, "R5 byte not stored under protection", d, 8'hFF);

    // R3/R4/R6: good write with ignored top bits, 33 bytes
    sel(1, 0, av, aok, ss, sv);
    send(8'hE0, av, aok);
    send(8'h00, av, aok);
    for (int i = 0; i < 33; i++) begin
      send(pat(i), av, aok);
      if (i < 32) chk(av && aok, "R4 bytes of first write accepted (R5 no lock)", {av, aok}, 3);
      else        chk(av && !aok, "R6 byte past page refused", {av, aok}, 2);
    end
    end_xfer();
    read_at(8'h00, d);
    chk(d == pat(0), "R6 offset 0 not overwritten", d, pat(0));

    // R4: second write refused
    sel(1, 0, av, aok, ss, sv);
    send(8'h00, av, aok);
    send(8'h00, av, aok);
    send(8'h77, av, aok);
    chk(av && !aok, "R4 second write refused", {av, aok}, 2);
    end_xfer();
    read_at(8'h01, d);
    chk(d == pat(1), "R4 contents kept after lock", d, pat(1));

    // R7: random reads from the vector table
    model_ptr = 2;
    foreach (RR_VEC[n]) begin
      logic [7:0] hi, lo;
      int exp_off;
      hi = RR_VEC[n][15:8];
      lo = RR_VEC[n][7:0];
      set_addr(hi, lo);
      exp_off = (hi[4:0] == 0 && lo[7:5] == 0) ? int'(lo[4:0]) : model_ptr;
      read_one(d);
      end_xfer();
      chk(d == pat(exp_off), "R7 random read", d, pat(exp_off));
      model_ptr = (exp_off + 1) % 32;
    end

    // R8: wrap across offset 31
    set_addr(8'h00, 8'd30);
    for (int i = 0; i < 4; i++) begin
      read_one(d);
      chk(d == pat((30 + i) % 32), "R8 sequential wrap", d, pat((30 + i) % 32));
    end
    end_xfer();

    // R9: handoff to the main array
    sel(0, 1, av, aok, ss, sv);
    chk(ss && sv == 12'd2, "R9 handoff after offset 1", {ss, sv}, {1'b1, 12'd2});
    chk(av == 0, "R10 no ack for main array", av, 0);
    end_xfer();
    sel(0, 1, av, aok, ss, sv);
    chk(ss == 0, "R9 no second handoff", ss, 0);
    end_xfer();
    read_at(8'd31, d);
    sel(0, 1, av, aok, ss, sv);
    chk(ss && sv == 12'd32, "R9 handoff after offset 31", {ss, sv}, {1'b1, 12'd32});
    end_xfer();
    sel(1, 0, av, aok, ss, sv);
    send(8'h00, av, aok);
    send(8'h05, av, aok);
    end_xfer();
    sel(0, 1, av, aok, ss, sv);
    chk(ss && sv == 12'd5, "R9 handoff after address load only", {ss, sv}, {1'b1, 12'd5});
    end_xfer();
    sel(0, 0, av, aok, ss, sv);
    chk(av == 0 && ss == 0, "R10 main write select ignored", {av, ss}, 0);
    end_xfer();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule